// File: doc/BRIEF.md
# CAN Controller Status Register

This block is the status word that a CAN controller presents to its host processor. A separate protocol engine supplies single-cycle strobes for a good received frame, a good acknowledged transmitted frame, a recovery-complete event and a bus error together with a 3-bit error type. It also supplies the current transmit and receive error counter values. From these inputs the block derives the bus-off, error-warning and error-passive flags. It keeps two sticky completion flags, one for receive and one for transmit, and it records the type of the most recent bus error.

The processor sees one 16-bit word and can write that word. A write only clears completion flags or loads the error-type field. The three condition flags follow the counters and ignore writes. All state is held in flip-flops, and the read word is built straight from them. A change at the inputs therefore shows in the read word one clock after the edge that samples it.

Top module: `can_stat_reg`

## Requirements
- R1: The read word places bus-off at bit 7, warning at bit 6, error-passive at bit 5, receive-OK at bit 4, transmit-OK at bit 3 and the last error code at bits 2:0. Bits 15:8 always read 0.
- R2: The warning flag is 1 when the transmit counter or the receive counter is 96 or more, and 0 when both counters are below 96.
- R3: The error-passive flag is 1 when either counter is 128 or more, and 0 otherwise.
- R4: The bus-off flag sets in any cycle where the transmit counter exceeds 255. It then stays at 1 until a recovery strobe arrives in a cycle where the transmit counter is at most 255.
- R5: A receive-success strobe sets receive-OK. Only a processor write with bit 4 = 0 clears it. Nothing else clears it.
- R6: A transmit-success strobe sets transmit-OK. Only a processor write with bit 3 = 0 clears it. Nothing else clears it.
- R7: When a success strobe and a processor clear of the same flag fall in the same cycle, the flag ends at 1.
- R8: An error strobe loads the error type into bits 2:0. The codes are 1 stuff, 2 form, 3 acknowledge, 4 bit-1, 5 bit-0 and 6 CRC.
- R9: A receive-success or transmit-success strobe without an error strobe loads code 0. An error strobe in the same cycle takes precedence over the success strobe.
- R10: In a cycle with no error or success strobe, a processor write loads bits 2:0 from write data bits 2:0, where code 7 serves as a host marker. Writes to bits 7:5 are ignored. Writing 1 to bit 4 or bit 3 does not set that flag.
- R11: A synchronous active-high reset makes the whole read word 0.
- R12: Every result shows in the read word exactly one clock edge after the edge that samples its stimulus, and it is not visible before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_done_i | input | 1 | Strobe: frame received without error |
| tx_done_i | input | 1 | Strobe: frame sent without error and acknowledged |
| err_evt_i | input | 1 | Strobe: bus error detected |
| err_type_i | input | 3 | Error type, valid with err_evt_i |
| tx_errcnt_i | input | CNT_W | Transmit error counter value |
| rx_errcnt_i | input | CNT_W | Receive error counter value |
| recov_done_i | input | 1 | Strobe: bus-off recovery finished |
| host_wr_i | input | 1 | Processor write enable |
| host_wdata_i | input | 16 | Processor write data |
| host_rdata_o | output | 16 | Status word |

## Verification
All state sits one register away from the inputs. Every field of the word is therefore due at the first clock edge after its stimulus is sampled. The bench drives inputs on the falling edge, advances its own model of the word at the same moment, and compares every field at the next falling edge, half a period after the rising edge that should have updated it. One directed check reads the word just after a strobe is applied and before any rising edge, and confirms that nothing has changed early. A later check confirms the change after exactly one edge.

// File: rtl/can_stat_pkg.sv
package can_stat_pkg;

  localparam int STAT_W = 16;

  // Field positions decoded by host software
  localparam int POS_BUSOFF  = 7;
  localparam int POS_WARN    = 6;
  localparam int POS_PASSIVE = 5;
  localparam int POS_RXOK    = 4;
  localparam int POS_TXOK    = 3;
  localparam int LEC_W       = 3;

  typedef enum logic [LEC_W-1:0] {
    LEC_NONE  = 3'd0,
    LEC_STUFF = 3'd1,
    LEC_FORM  = 3'd2,
    LEC_ACK   = 3'd3,
    LEC_BIT1  = 3'd4,
    LEC_BIT0  = 3'd5,
    LEC_CRC   = 3'd6,
    LEC_KEEP  = 3'd7
  } lec_e;

  // index of each sticky completion flag
  localparam int OK_RX = 0;
  localparam int OK_TX = 1;
  localparam int OK_N  = 2;

endpackage

// File: rtl/can_stat_thresh.sv
module can_stat_thresh #(
  parameter int CNT_W         = 9,
  parameter int WARN_LIMIT    = 96,
  parameter int PASSIVE_LIMIT = 128,
  parameter int BUSOFF_LIMIT  = 255
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] tx_cnt_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic             recov_i,
  output logic             busoff_o,
  output logic             warn_o,
  output logic             passive_o
);

  localparam logic [CNT_W-1:0] WARN_L = CNT_W'(WARN_LIMIT);
  localparam logic [CNT_W-1:0] PASS_L = CNT_W'(PASSIVE_LIMIT);
  localparam logic [CNT_W-1:0] BOFF_L = CNT_W'(BUSOFF_LIMIT);

  logic warn_hit, pass_hit, boff_hit;

  always_comb begin
    warn_hit = (tx_cnt_i >= WARN_L) || (rx_cnt_i >= WARN_L);
    pass_hit = (tx_cnt_i >= PASS_L) || (rx_cnt_i >= PASS_L);
    boff_hit = (tx_cnt_i > BOFF_L);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      warn_o    <= 1'b0;
      passive_o <= 1'b0;
      busoff_o  <= 1'b0;
    end else begin
      warn_o    <= warn_hit;
      passive_o <= pass_hit;
      if (boff_hit)
        busoff_o <= 1'b1;
      else if (recov_i)
        busoff_o <= 1'b0;
    end
  end

  AST_WARN_LOW: assert property (@(posedge clk) disable iff (rst) (tx_cnt_i < WARN_L && rx_cnt_i < WARN_L) |=> !warn_o); // R2
  AST_PASS_HIGH: assert property (@(posedge clk) disable iff (rst) (rx_cnt_i >= PASS_L) |=> passive_o); // R3
  AST_BUSOFF_SET: assert property (@(posedge clk) disable iff (rst) (tx_cnt_i > BOFF_L) |=> busoff_o); // R4
  AST_BUSOFF_HOLD: assert property (@(posedge clk) disable iff (rst) (busoff_o && !recov_i) |=> busoff_o); // R4

endmodule

// File: rtl/can_stat_sticky.sv
module can_stat_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  // a completion strobe outranks a host clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst)
      flag_o <= 1'b0;
    else if (set_i)
      flag_o <= 1'b1;
    else if (clr_i)
      flag_o <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst) set_i |=> flag_o); // R7
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst) (flag_o && !clr_i) |=> flag_o); // R5 R6
  AST_NO_SELF_SET: assert property (@(posedge clk) disable iff (rst) (!flag_o && !set_i) |=> !flag_o); // R10

endmodule

// File: rtl/can_stat_lec.sv
module can_stat_lec
  import can_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             err_evt_i,
  input  logic [LEC_W-1:0] err_type_i,
  input  logic             frame_ok_i,
  input  logic             host_wr_i,
  input  logic [LEC_W-1:0] host_code_i,
  output logic [LEC_W-1:0] lec_o
);

  lec_e lec_q;

  // priority: bus error, then good frame, then host write
  always_ff @(posedge clk) begin
    if (rst)
      lec_q <= LEC_NONE;
    else if (err_evt_i)
      lec_q <= lec_e'(err_type_i);
    else if (frame_ok_i)
      lec_q <= LEC_NONE;
    else if (host_wr_i)
      lec_q <= lec_e'(host_code_i);
  end

  assign lec_o = lec_q;

  AST_LEC_ERR: assert property (@(posedge clk) disable iff (rst) err_evt_i |=> (lec_o == $past(err_type_i))); // R8
  AST_LEC_OK: assert property (@(posedge clk) disable iff (rst) (!err_evt_i && frame_ok_i) |=> (lec_o == LEC_NONE)); // R9
  AST_LEC_IDLE: assert property (@(posedge clk) disable iff (rst) (!err_evt_i && !frame_ok_i && !host_wr_i) |=> $stable(lec_o)); // R10

endmodule

// File: rtl/can_stat_reg.sv
module can_stat_reg
  import can_stat_pkg::*;
#(
  parameter int CNT_W         = 9,
  parameter int WARN_LIMIT    = 96,
  parameter int PASSIVE_LIMIT = 128,
  parameter int BUSOFF_LIMIT  = 255
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_done_i,
  input  logic              tx_done_i,
  input  logic              err_evt_i,
  input  logic [2:0]        err_type_i,
  input  logic [CNT_W-1:0]  tx_errcnt_i,
  input  logic [CNT_W-1:0]  rx_errcnt_i,
  input  logic              recov_done_i,
  input  logic              host_wr_i,
  input  logic [STAT_W-1:0] host_wdata_i,
  output logic [STAT_W-1:0] host_rdata_o
);

  localparam int RSV_W = STAT_W - POS_BUSOFF - 1;
  localparam int OK_POS [OK_N] = '{POS_RXOK, POS_TXOK};

  logic             busoff, warn, passive;
  logic [OK_N-1:0]  ok_set, ok_clr, ok_flag;
  logic [LEC_W-1:0] lec;

  can_stat_thresh #(
    .CNT_W        (CNT_W),
    .WARN_LIMIT   (WARN_LIMIT),
    .PASSIVE_LIMIT(PASSIVE_LIMIT),
    .BUSOFF_LIMIT (BUSOFF_LIMIT)
  ) thresh_i (
    .clk      (clk),
    .rst      (rst),
    .tx_cnt_i (tx_errcnt_i),
    .rx_cnt_i (rx_errcnt_i),
    .recov_i  (recov_done_i),
    .busoff_o (busoff),
    .warn_o   (warn),
    .passive_o(passive)
  );

  assign ok_set[OK_RX] = rx_done_i;
  assign ok_set[OK_TX] = tx_done_i;

  generate
    for (genvar g = 0; g < OK_N; g++) begin : g_ok
      assign ok_clr[g] = host_wr_i && !host_wdata_i[OK_POS[g]];
      can_stat_sticky flag_i (
        .clk   (clk),
        .rst   (rst),
        .set_i (ok_set[g]),
        .clr_i (ok_clr[g]),
        .flag_o(ok_flag[g])
      );
    end
  endgenerate

  can_stat_lec lec_i (
    .clk        (clk),
    .rst        (rst),
    .err_evt_i  (err_evt_i),
    .err_type_i (err_type_i),
    .frame_ok_i (rx_done_i || tx_done_i),
    .host_wr_i  (host_wr_i),
    .host_code_i(host_wdata_i[LEC_W-1:0]),
    .lec_o      (lec)
  );

  // all fields are flop outputs; the word is pure wiring
  assign host_rdata_o = {{RSV_W{1'b0}}, busoff, warn, passive,
                         ok_flag[OK_RX], ok_flag[OK_TX], lec};

  AST_PASSIVE_WARN: assert property (@(posedge clk) disable iff (rst) (passive && (PASSIVE_LIMIT >= WARN_LIMIT)) |-> warn); // R3
  AST_RX_SET: assert property (@(posedge clk) disable iff (rst) rx_done_i |=> host_rdata_o[POS_RXOK]); // R5
  AST_TX_SET: assert property (@(posedge clk) disable iff (rst) tx_done_i |=> host_rdata_o[POS_TXOK]); // R6
  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (host_rdata_o == '0)); // R11

endmodule

// File: tb/can_stat_reg_tb.sv
module can_stat_reg_tb_top;

  localparam int CNT_W = 9;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             rx_done = 1'b0, tx_done = 1'b0, err_evt = 1'b0, recov = 1'b0;
  logic [2:0]       err_type = 3'd0;
  logic [CNT_W-1:0] tec = '0, rec = '0;
  logic             host_wr = 1'b0;
  logic [15:0]      wdata = 16'h0;
  logic [15:0]      rdata;
  logic [15:0]      expw = 16'h0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  can_stat_reg #(.CNT_W(CNT_W)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .rx_done_i   (rx_done),
    .tx_done_i   (tx_done),
    .err_evt_i   (err_evt),
    .err_type_i  (err_type),
    .tx_errcnt_i (tec),
    .rx_errcnt_i (rec),
    .recov_done_i(recov),
    .host_wr_i   (host_wr),
    .host_wdata_i(wdata),
    .host_rdata_o(rdata)
  );

  // next expected word from the requirements
  function automatic logic [15:0] model_next(logic [15:0] s);
    logic bo, wn, ps, rxo, txo;
    logic [2:0] lc;
    if (rst) return 16'h0;                                   // R11
    bo = s[7];
    if (tec > 255) bo = 1'b1; else if (recov) bo = 1'b0;     // R4
    wn = (tec >= 96) || (rec >= 96);                         // R2
    ps = (tec >= 128) || (rec >= 128);                       // R3
    rxo = rx_done ? 1'b1 : (host_wr && !wdata[4]) ? 1'b0 : s[4];
    txo = tx_done ? 1'b1 : (host_wr && !wdata[3]) ? 1'b0 : s[3];
    lc = err_evt ? err_type : (rx_done || tx_done) ? 3'd0 : host_wr ? wdata[2:0] : s[2:0];
    return {8'h00, bo, wn, ps, rxo, txo, lc};
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exv);
    checks++;
    if (act !== exv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exv);
    end
  endtask

  task automatic compare_all();
    check("R1 reserved",  {8'h0, rdata[15:8]}, {8'h0, expw[15:8]});
    check("R4 busoff",    {15'h0, rdata[7]},   {15'h0, expw[7]});
    check("R2 warning",   {15'h0, rdata[6]},   {15'h0, expw[6]});
    check("R3 passive",   {15'h0, rdata[5]},   {15'h0, expw[5]});
    check("R5 rx ok",     {15'h0, rdata[4]},   {15'h0, expw[4]});
    check("R6 tx ok",     {15'h0, rdata[3]},   {15'h0, expw[3]});
    check("R8 lec",       {13'h0, rdata[2:0]}, {13'h0, expw[2:0]});
  endtask

  // called just after a falling edge with inputs set
  task automatic tick();
    expw = model_next(expw);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    rx_done = 0; tx_done = 0; err_evt = 0; recov = 0; host_wr = 0;
    err_type = 0; wdata = 16'h0;
  endtask

  function automatic logic [CNT_W-1:0] pick_cnt();
    case ($urandom % 8)
      0: return 9'd0;
      1: return 9'd95;
      2: return 9'd96;
      3: return 9'd127;
      4: return 9'd128;
      5: return 9'd255;
      6: return 9'd256;
      default: return 9'($urandom % 512);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    rst = 1; idle();
    tick(); tick();
    check("R11 reset word", rdata, 16'h0000);
    rst = 0;

    // R12: no early visibility, exactly one edge later
    rx_done = 1;
    #1 check("R12 before edge", {15'h0, rdata[4]}, 16'h0);
    tick();
    check("R12 rx ok after one edge", {15'h0, rdata[4]}, 16'h1);
    idle();

    // R7: set and clear of receive-OK in one cycle
    rx_done = 1; host_wr = 1; wdata = 16'h0000;
    tick();
    check("R7 strobe beats clear", {15'h0, rdata[4]}, 16'h1);
    idle(); host_wr = 1; wdata = 16'h0000;
    tick();
    check("R5 host clear", {15'h0, rdata[4]}, 16'h0);

    // R6 sticky transmit-OK
    idle(); tx_done = 1; tick();
    idle(); tick(); tick();
    check("R6 tx ok stays", {15'h0, rdata[3]}, 16'h1);
    host_wr = 1; wdata = 16'h0; tick(); idle();

    // R10 write all ones: only the code field changes
    host_wr = 1; wdata = 16'hFFFF; tick(); idle();
    check("R10 write ones", rdata, 16'h0007);

    // R8 each error type
    for (int k = 1; k <= 6; k++) begin
      err_evt = 1; err_type = 3'(k); tick();
      check("R8 error code", {13'h0, rdata[2:0]}, 16'(k));
    end
    idle();

    // R9 success clears code; error wins over success
    tx_done = 1; tick();
    check("R9 success writes 0", {13'h0, rdata[2:0]}, 16'h0);
    idle(); err_evt = 1; err_type = 3'd3; rx_done = 1; tick();
    check("R9 error beats success", {13'h0, rdata[2:0]}, 16'h3);
    idle();

    // R2 / R3 thresholds
    tec = 9'd96; rec = 9'd0; tick();
    check("R2 warn at 96", rdata[7:5], 16'h2);
    tec = 9'd0; rec = 9'd128; tick();
    check("R3 passive at 128", rdata[7:5], 16'h3);
    tec = 9'd95; rec = 9'd95; tick();
    check("R2 below limit", rdata[7:5], 16'h0);

    // R4 bus-off hold and recovery
    tec = 9'd256; tick();
    check("R4 busoff set", {15'h0, rdata[7]}, 16'h1);
    tec = 9'd0; tick();
    check("R4 busoff held", {15'h0, rdata[7]}, 16'h1);
    tec = 9'd300; recov = 1; tick();
    check("R4 recovery while over", {15'h0, rdata[7]}, 16'h1);
    tec = 9'd0; recov = 1; tick();
    check("R4 recovery clears", {15'h0, rdata[7]}, 16'h0);
    idle();

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      rst      = (n == 1500);
      rx_done  = ($urandom % 6) == 0;
      tx_done  = ($urandom % 6) == 0;
      err_evt  = ($urandom % 5) == 0;
      err_type = 3'($urandom % 8);
      recov    = ($urandom % 6) == 0;
      host_wr  = ($urandom % 4) == 0;
      wdata    = 16'($urandom);
      tec      = pick_cnt();
      rec      = pick_cnt();
      tick();
    end
    rst = 0; idle();

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule